// File: doc/BRIEF.md
# Grouped Multi-DAC Frame Scheduler

This block drives three serial DACs that share one clock line and one data line. Each DAC has its own chip select. The twelve output channels form four groups of three: group 0 holds A1..A3, group 1 holds B1..B3, group 2 holds C1..C3 and group 3 holds D1..D3. Each DAC owns one channel of every group. A 2-bit group setting `g` enables groups 0 through `g`.

In each sample period the block sends every enabled group in turn. For each group it sends one 24-bit word to every DAC, so each group costs 72 bits whether or not all of its channels are in use. At the first clock of a period the block takes a copy of all twelve parallel sample words and of the group setting. It also raises a one-clock request, which tells the wave generators to start computing the next samples while this transfer runs. The transfer length alone therefore sets the sample rate.

Fixed overhead cycles around the words give periods of 154, 302, 450 and 598 clocks for `g` = 0..3.

Top module: `dac_frame_sched`

## Requirements
- R1: Channel `ch = 3*grp + dac` is taken from `smp_bus[24*ch +: 24]`. Words go out with groups in ascending order. Within a group, DAC 0, 1 and 2 follow in that order, and each word goes out while `dac_cs_n[dac]` alone is low.
- R2: With group setting `g`, a period carries exactly `3*(g+1)` words, which is `72*(g+1)` bits. Channels of groups above `g` are never sent.
- R3: Successive `next_req` pulses are exactly `154 + 148*g` clocks apart, where `g` is the setting latched at the first of the two pulses.
- R4: Each word holds its chip select low for 48 clocks. It carries 24 rising edges of `dac_sclk` and is sent MSB first. `dac_sdata` does not change in a cycle where `dac_sclk` is high.
- R5: At most one chip select is low at a time. `dac_sclk` is low whenever all chip selects are high.
- R6: When a chip select rises, all chip selects are high in that cycle. There is no direct hand-off from one DAC to the next.
- R7: `next_req` is a one-clock pulse. The sample words and the group setting are captured at the edge that raises it. Changes on `smp_bus` or `grp_sel` later in the period do not alter the words sent or the period length.
- R8: The first chip select of a period falls exactly 4 clocks after `next_req` is high.
- R9: Reset is asynchronous and active low. While it is asserted, `dac_cs_n` = 3'b111 and `dac_sclk`, `dac_sdata` and `next_req` are 0. After release, `next_req` is high following the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_sel | input | 2 | Highest enabled group, latched per period |
| smp_bus | input | 288 | Twelve 24-bit sample words, channel `ch` at bits `24*ch +: 24` |
| next_req | output | 1 | One-clock pulse at period start: samples latched, compute next |
| dac_sclk | output | 1 | Shared serial clock, idles low |
| dac_sdata | output | 1 | Shared serial data, MSB first |
| dac_cs_n | output | 3 | Active-low chip select, one per DAC |

## Verification
Every output comes from a register one clock behind the phase counter. `next_req` rises one clock after the edge that captures the inputs. The first chip select follows it by 4 clocks, and the next pulse comes 154 + 148·g clocks later.

The bench samples only on falling edges. It counts cycles relative to the observed `next_req` pulse rather than to absolute time, so all of these offsets are measured from the same register stage. The bench changes the inputs on the falling edge right after a pulse, which places the change after the capture edge. Each period is then checked against the values presented before that pulse.

// File: rtl/dsch_pkg.sv
package dsch_pkg;

  typedef enum logic [2:0] {
    PH_START = 3'd0,
    PH_SHIFT = 3'd1,
    PH_WGAP  = 3'd2,
    PH_GGAP  = 3'd3,
    PH_STOP  = 3'd4
  } phase_e;

  // Clocks in one sample period for group setting g.
  function automatic int frame_period(input int g, input int start_c, input int stop_c,
                                      input int word_c, input int wgap, input int ggap,
                                      input int ndac);
    return start_c + stop_c + (g + 1) * (ndac * (word_c + wgap) + ggap);
  endfunction

  // Bit position sent at phase count c, most significant bit first.
  function automatic int msb_first_pos(input int c, input int cpb, input int ww);
    int p;
    p = ww - 1 - (c / cpb);
    return (p < 0) ? 0 : p;
  endfunction

  // Serial clock level within one bit slot: low first half, high second half.
  function automatic logic sclk_level(input int c, input int cpb);
    return ((c % cpb) >= (cpb / 2));
  endfunction

endpackage

// File: rtl/dsch_timer.sv
module dsch_timer
  import dsch_pkg::*;
#(
  parameter int N_DAC       = 3,
  parameter int N_GRP       = 4,
  parameter int WORD_CYC    = 48,
  parameter int START_CYC   = 4,
  parameter int STOP_CYC    = 2,
  parameter int WORD_GAP    = 1,
  parameter int GROUP_GAP   = 1,
  parameter int CNT_W       = 6,
  localparam int DAC_W      = (N_DAC > 1) ? $clog2(N_DAC) : 1,
  localparam int GRP_W      = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] grp_lim,
  output logic             frame_go,
  output logic             shifting,
  output logic [DAC_W-1:0] dac_idx,
  output logic [GRP_W-1:0] grp_idx,
  output logic [CNT_W-1:0] cnt
);

  phase_e ph;

  assign frame_go = (ph == PH_START) && (cnt == '0);
  assign shifting = (ph == PH_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_START;
      cnt     <= '0;
      dac_idx <= '0;
      grp_idx <= '0;
    end else begin
      case (ph)
        PH_START: begin
          if (cnt == CNT_W'(START_CYC - 1)) begin
            ph      <= PH_SHIFT;
            cnt     <= '0;
            dac_idx <= '0;
            grp_idx <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_SHIFT: begin
          if (cnt == CNT_W'(WORD_CYC - 1)) begin
            ph  <= PH_WGAP;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_WGAP: begin
          if (cnt == CNT_W'(WORD_GAP - 1)) begin
            cnt <= '0;
            if (dac_idx == DAC_W'(N_DAC - 1)) begin
              ph      <= PH_GGAP;
              dac_idx <= '0;
            end else begin
              ph      <= PH_SHIFT;
              dac_idx <= dac_idx + DAC_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_GGAP: begin
          if (cnt == CNT_W'(GROUP_GAP - 1)) begin
            cnt <= '0;
            if (grp_idx == grp_lim) begin
              ph <= PH_STOP;
            end else begin
              ph      <= PH_SHIFT;
              grp_idx <= grp_idx + GRP_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_STOP: begin
          if (cnt == CNT_W'(STOP_CYC - 1)) begin
            ph  <= PH_START;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          ph  <= PH_START;
          cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dsch_hold.sv
module dsch_hold #(
  parameter int N_DAC  = 3,
  parameter int N_GRP  = 4,
  parameter int WORD_W = 24,
  localparam int N_CH  = N_DAC * N_GRP,
  localparam int BUS_W = N_CH * WORD_W,
  localparam int DAC_W = (N_DAC > 1) ? $clog2(N_DAC) : 1,
  localparam int GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic [BUS_W-1:0]  smp_bus,
  input  logic [GRP_W-1:0]  grp_sel,
  input  logic [GRP_W-1:0]  grp_idx,
  input  logic [DAC_W-1:0]  dac_idx,
  output logic [GRP_W-1:0]  grp_lat,
  output logic [WORD_W-1:0] cur_word
);

  logic [BUS_W-1:0]  hold_q;
  logic [WORD_W-1:0] words [N_CH];
  int                sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      grp_lat <= '0;
    end else if (frame_go) begin
      hold_q  <= smp_bus;
      grp_lat <= grp_sel;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_word
    assign words[ch] = hold_q[ch*WORD_W +: WORD_W];
  end

  always_comb begin
    sel      = int'(grp_idx) * N_DAC + int'(dac_idx);
    cur_word = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (ch == sel) cur_word = words[ch];
    end
  end

endmodule

// File: rtl/dsch_drive.sv
module dsch_drive
  import dsch_pkg::*;
#(
  parameter int N_DAC       = 3,
  parameter int WORD_W      = 24,
  parameter int CLK_PER_BIT = 2,
  parameter int CNT_W       = 6,
  localparam int DAC_W      = (N_DAC > 1) ? $clog2(N_DAC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic              shifting,
  input  logic [DAC_W-1:0]  dac_idx,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [WORD_W-1:0] cur_word,
  output logic              next_req,
  output logic              dac_sclk,
  output logic              dac_sdata,
  output logic [N_DAC-1:0]  dac_cs_n
);

  logic             sclk_d;
  logic             sdata_d;
  logic [N_DAC-1:0] cs_d;

  always_comb begin
    sclk_d  = shifting && sclk_level(int'(cnt), CLK_PER_BIT);
    sdata_d = shifting ? cur_word[msb_first_pos(int'(cnt), CLK_PER_BIT, WORD_W)] : 1'b0;
    cs_d    = shifting ? ~(N_DAC'(1) << dac_idx) : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_req  <= 1'b0;
      dac_sclk  <= 1'b0;
      dac_sdata <= 1'b0;
      dac_cs_n  <= '1;
    end else begin
      next_req  <= frame_go;
      dac_sclk  <= sclk_d;
      dac_sdata <= sdata_d;
      dac_cs_n  <= cs_d;
    end
  end

endmodule

// File: rtl/dac_frame_sched.sv
module dac_frame_sched #(
  parameter int N_DAC       = 3,
  parameter int N_GRP       = 4,
  parameter int WORD_W      = 24,
  parameter int CLK_PER_BIT = 2,
  parameter int START_CYC   = 4,
  parameter int STOP_CYC    = 2,
  parameter int WORD_GAP    = 1,
  parameter int GROUP_GAP   = 1,
  localparam int N_CH       = N_DAC * N_GRP,
  localparam int BUS_W      = N_CH * WORD_W,
  localparam int WORD_CYC   = WORD_W * CLK_PER_BIT,
  localparam int MAX_PH     = (WORD_CYC > START_CYC) ? WORD_CYC : START_CYC,
  localparam int CNT_W      = $clog2(MAX_PH + 1),
  localparam int DAC_W      = (N_DAC > 1) ? $clog2(N_DAC) : 1,
  localparam int GRP_W      = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] grp_sel,
  input  logic [BUS_W-1:0] smp_bus,
  output logic             next_req,
  output logic             dac_sclk,
  output logic             dac_sdata,
  output logic [N_DAC-1:0] dac_cs_n
);

  logic              frame_go;
  logic              shifting;
  logic [DAC_W-1:0]  dac_idx;
  logic [GRP_W-1:0]  grp_idx;
  logic [GRP_W-1:0]  grp_lat;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] cur_word;

  dsch_timer #(
    .N_DAC(N_DAC), .N_GRP(N_GRP), .WORD_CYC(WORD_CYC), .START_CYC(START_CYC),
    .STOP_CYC(STOP_CYC), .WORD_GAP(WORD_GAP), .GROUP_GAP(GROUP_GAP), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .grp_lim(grp_lat), .frame_go(frame_go),
    .shifting(shifting), .dac_idx(dac_idx), .grp_idx(grp_idx), .cnt(cnt)
  );

  dsch_hold #(
    .N_DAC(N_DAC), .N_GRP(N_GRP), .WORD_W(WORD_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .smp_bus(smp_bus),
    .grp_sel(grp_sel), .grp_idx(grp_idx), .dac_idx(dac_idx),
    .grp_lat(grp_lat), .cur_word(cur_word)
  );

  dsch_drive #(
    .N_DAC(N_DAC), .WORD_W(WORD_W), .CLK_PER_BIT(CLK_PER_BIT), .CNT_W(CNT_W)
  ) u_drive (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .shifting(shifting),
    .dac_idx(dac_idx), .cnt(cnt), .cur_word(cur_word), .next_req(next_req),
    .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_cs_n(dac_cs_n)
  );

endmodule

// File: rtl/dsch_chk.sv
module dsch_chk
  import dsch_pkg::*;
#(
  parameter int N_DAC       = 3,
  parameter int N_GRP       = 4,
  parameter int WORD_W      = 24,
  parameter int CLK_PER_BIT = 2,
  parameter int START_CYC   = 4,
  parameter int STOP_CYC    = 2,
  parameter int WORD_GAP    = 1,
  parameter int GROUP_GAP   = 1,
  localparam int WORD_CYC   = WORD_W * CLK_PER_BIT,
  localparam int GRP_W      = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             next_req,
  input logic             dac_sclk,
  input logic             dac_sdata,
  input logic [N_DAC-1:0] dac_cs_n,
  input logic [GRP_W-1:0] grp_lat
);

  int unsigned      per_cnt;
  int unsigned      low_cnt;
  logic             seen_req;
  logic [GRP_W-1:0] grp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= 0;
      low_cnt  <= 0;
      seen_req <= 1'b0;
      grp_prev <= '0;
    end else begin
      per_cnt <= next_req ? 1 : per_cnt + 1;
      low_cnt <= (&dac_cs_n) ? 0 : low_cnt + 1;
      if (next_req) begin
        seen_req <= 1'b1;
        grp_prev <= grp_lat;
      end
    end
  end

  // R3: period length between request pulses
  p_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (next_req && seen_req) |->
      (per_cnt == frame_period(int'(grp_prev), START_CYC, STOP_CYC, WORD_CYC,
                               WORD_GAP, GROUP_GAP, N_DAC)));

  // R4: chip select low for one full word
  p_word_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&dac_cs_n) && !(&$past(dac_cs_n))) |-> (low_cnt == WORD_CYC));

  // R4: data held while serial clock is high
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> $stable(dac_sdata));

  // R5: one chip select at a time
  p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dac_cs_n) <= 1);

  // R5: serial clock idles low outside words
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&dac_cs_n) |-> !dac_sclk);

  // R6: release of a chip select leaves the bus idle
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dac_cs_n & ~$past(dac_cs_n))) |-> (&dac_cs_n));

  // R7: request is a single-cycle pulse
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |=> !next_req);

  // R7: latched group only changes with a request
  p_grp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !next_req |-> $stable(grp_lat));

endmodule

bind dac_frame_sched dsch_chk #(
  .N_DAC(N_DAC), .N_GRP(N_GRP), .WORD_W(WORD_W), .CLK_PER_BIT(CLK_PER_BIT),
  .START_CYC(START_CYC), .STOP_CYC(STOP_CYC), .WORD_GAP(WORD_GAP), .GROUP_GAP(GROUP_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .next_req(next_req), .dac_sclk(dac_sclk),
  .dac_sdata(dac_sdata), .dac_cs_n(dac_cs_n), .grp_lat(grp_lat)
);

// File: tb/sim_dac_frame_sched.sv
`timescale 1ns/1ps
module sim_dac_frame_sched;

  localparam int N_CH  = 12;
  localparam int WW    = 24;
  localparam int BUS_W = N_CH * WW;
  localparam int NV    = 6;
  // {group setting, base pattern}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 24'hFFFFFF}, {2'd3, 24'h000000}, {2'd1, 24'hA5A5A5},
    {2'd2, 24'h123456}, {2'd3, 24'h800001}, {2'd0, 24'h7FFFFE}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       grp_sel = '0;
  logic [BUS_W-1:0] smp_bus = '0;
  logic             next_req, dac_sclk, dac_sdata;
  logic [2:0]       dac_cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_frame_sched u0 (
    .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel), .smp_bus(smp_bus),
    .next_req(next_req), .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_cs_n(dac_cs_n)
  );

  function automatic logic [WW-1:0] exp_word(input logic [WW-1:0] base, input int ch);
    return base ^ (WW'(ch) * 24'h1B3A57);
  endfunction

  function automatic logic [BUS_W-1:0] mk_bus(input logic [WW-1:0] base);
    logic [BUS_W-1:0] b;
    for (int ch = 0; ch < N_CH; ch++) b[ch*WW +: WW] = exp_word(base, ch);
    return b;
  endfunction

  function automatic int exp_period(input int g);
    return 154 + 148 * g;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [25:0] v);
    grp_sel = v[25:24];
    smp_bus = mk_bus(v[23:0]);
  endtask

  // Called on the falling edge where next_req is high; returns on the next such edge.
  task automatic watch_period(input logic [1:0] g, input logic [WW-1:0] base);
    int cyc = 0, nword = 0, nbits = 0, first_low = -1, idle_bad = 0;
    logic [2:0] prev_cs = 3'b111;
    logic prev_sclk = 1'b0;
    logic [WW-1:0] acc = '0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (next_req || cyc > 2000) break;
      if ((&dac_cs_n) && dac_sclk) idle_bad++;
      if (!(&dac_cs_n) && first_low < 0) first_low = cyc;
      if (!(&dac_cs_n) && !prev_sclk && dac_sclk) begin
        acc = {acc[WW-2:0], dac_sdata};
        nbits++;
      end
      for (int d = 0; d < 3; d++) begin
        if (!prev_cs[d] && dac_cs_n[d]) begin
          int ch = (nword / 3) * 3 + d;
          check(d == nword % 3, "R1", "DAC order", d, nword % 3);
          check(acc == exp_word(base, (nword / 3) * 3 + (nword % 3)), "R1 R7",
                "word content", acc, exp_word(base, (nword / 3) * 3 + (nword % 3)));
          check(nbits == 24, "R4", "sclk edges per word", nbits, 24);
          if (ch < 0) idle_bad++;
          nword++;
          nbits = 0;
          acc = '0;
        end
      end
      prev_cs = dac_cs_n;
      prev_sclk = dac_sclk;
    end
    check(cyc == exp_period(int'(g)), "R3", "period length", cyc, exp_period(int'(g)));
    check(nword == 3 * (int'(g) + 1), "R2", "words per period", nword, 3 * (int'(g) + 1));
    check(first_low == 4, "R8", "first select offset", first_low, 4);
    check(idle_bad == 0, "R5", "sclk high while idle", idle_bad, 0);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    apply(VEC[0]);
    repeat (3) @(negedge clk);
    // R9: idle outputs in reset
    check(dac_cs_n == 3'b111, "R9", "cs_n in reset", dac_cs_n, 3'b111);
    check(dac_sclk == 1'b0 && dac_sdata == 1'b0, "R9", "sclk/sdata in reset",
          {dac_sclk, dac_sdata}, 0);
    check(next_req == 1'b0, "R9", "next_req in reset", next_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(next_req == 1'b1, "R9", "request after first edge", next_req, 1);

    // Vector walk: inputs move to the next entry right after capture (R7).
    for (int i = 0; i < NV; i++) begin
      apply(VEC[(i + 1) % NV]);
      watch_period(VEC[i][25:24], VEC[i][23:0]);
    end

    @(negedge clk);
    check(next_req == 1'b0, "R7", "request pulse width", next_req, 0);

    // Reset in the middle of a word transfer
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check(dac_cs_n == 3'b111, "R9", "cs_n after async reset", dac_cs_n, 3'b111);
    check(dac_sclk == 1'b0 && next_req == 1'b0, "R9", "sclk/req after async reset",
          {dac_sclk, next_req}, 0);
    apply({2'd2, 24'h5C3E91});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(next_req == 1'b1, "R9", "restart request", next_req, 1);
    apply({2'd0, 24'h000FFF});
    watch_period(2'd2, 24'h5C3E91);
    apply({2'd0, 24'h000FFF});
    watch_period(2'd0, 24'h000FFF);

    finish_sim();
  end

endmodule